// File: doc/BRIEF.md
# Clock-Recovery Lock Detector

This block decides whether a clock-recovery loop may stay locked to incoming serial data or must be steered back to the local reference clock. It watches two things. The first is the length of runs of identical bits in the serial stream, sampled on the recovered bit clock. The second is the rate of the recovered clock, counted against a fixed window of reference-clock cycles. A separate signal-detect input from the optical front end overrides both checks.

Lock is declared only after two back-to-back frequency windows pass while no run-length fault and no signal loss occur. Any run fault or signal loss drops lock at once. A failed frequency window drops lock when that window ends. While unlocked, the block keeps measuring, so it reacquires on its own once the data is healthy again. The lock and steering outputs are registered in the reference domain.

The recovered clock is first divided by a prescaler. The divided count is then carried across domains as a Gray code. Every other crossing uses a two-flop synchronizer. The two-bit reference setting selects how many recovered-clock cycles one reference cycle is expected to hold.

Top module: `cdr_lock_detect`

## Requirements
- R1: While reset is asserted and right after it, `lock_o` is 0 and `force_ref_o` is 1.
- R2: Lock rises only at the end of the second consecutive window of `WIN` reference cycles in which the frequency check passed, with no run fault and no signal loss during either window.
- R3: A run of 80 identical serial bits forces the out-of-lock state within a few reference cycles. Runs of 79 bits never do.
- R4: The frequency check passes when the divided recovered-clock count over one window is within ±tol of `WIN*K/PRE`. K is the bits-per-reference-cycle ratio: `ref_sel` 00→32, 01→16, 10→12, 11→8. tol is `max(1, expected*PPM/1e6)`.
- R5: `sig_det` low forces the out-of-lock state within a few reference cycles, whatever the other checks say.
- R6: `force_ref_o` is always the complement of `lock_o`.
- R7: While locked, a window whose frequency check fails drops lock at the end of that window.
- R8: After a fault clears, the block reacquires lock without outside help, after two consecutive good windows.
- R9: The run-length counter saturates at 80. Serial data held constant keeps the block out of lock for as long as it stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rec | input | 1 | Recovered bit clock |
| clk_ref | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_din | input | 1 | Serial data, sampled on `clk_rec` |
| sig_det | input | 1 | Signal-detect from the optical front end, asynchronous |
| ref_sel | input | 2 | Reference-rate setting (ratio code of R4), static in operation |
| lock_o | output | 1 | Loop is locked to data (reference domain) |
| force_ref_o | output | 1 | Steer the loop to the reference clock |

## Verification
The hardest situations to reach from the ports are a run of exactly 80 identical bits against one of 79, and a recovered clock that is off-rate by only a few counts per window. The bench drives the serial input from a run-length generator with chosen run lengths. It sets the reference clock period per vector, so the recovered-to-reference ratio can match the setting, mismatch it, or be skewed by ten percent. It also removes and restores each fault while locked, which covers both the immediate drops and the two-window reacquisition.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

  typedef enum logic [1:0] {
    LK_HUNT    = 2'd0,
    LK_CONFIRM = 2'd1,
    LK_HELD    = 2'd2
  } lk_state_e;

  // recovered bit clocks per reference clock, per rate setting
  function automatic int unsigned ref_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32;
      2'd1:    return 16;
      2'd2:    return 12;
      default: return 8;
    endcase
  endfunction

  // divided recovered-clock count expected over one window
  function automatic int unsigned win_expect(input int unsigned win,
                                             input int unsigned pre,
                                             input logic [1:0] sel);
    return (win * ref_ratio(sel)) / pre;
  endfunction

  // tolerance in counts, never below one count
  function automatic int unsigned win_tol(input int unsigned expv,
                                          input int unsigned ppm);
    longint unsigned t;
    t = (longint'(expv) * longint'(ppm)) / 64'd1000000;
    if (t < 64'd1) t = 64'd1;
    return 32'(t);
  endfunction

endpackage

// File: rtl/ld_sync2.sv
module ld_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ld_run_monitor.sv
module ld_run_monitor #(
  parameter int RUN_LIMIT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic run_tgl_o,
  output logic run_sat_o
);
  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam logic [RW-1:0] LIM = RW'(RUN_LIMIT);

  logic [RW-1:0] run_cnt, cnt_n;
  logic          prev_q, tgl_q, sat_q;

  always_comb begin
    cnt_n = run_cnt;
    if (din != prev_q)    cnt_n = RW'(1);
    else if (run_cnt != LIM) cnt_n = run_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= RW'(1);
      prev_q  <= 1'b0;
      tgl_q   <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      run_cnt <= cnt_n;
      prev_q  <= din;
      sat_q   <= (cnt_n == LIM);
      if (din == prev_q && run_cnt == LIM - 1'b1) tgl_q <= ~tgl_q;
    end
  end

  assign run_tgl_o = tgl_q;
  assign run_sat_o = sat_q;

  // R9
  run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= RW'(1)) && (run_cnt <= LIM));

  // R3
  run_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_q) |-> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/ld_rate_tally.sv
module ld_rate_tally #(
  parameter int PRE = 64,
  parameter int CW  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] gray_o
);
  localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;

  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] bin_q, bin_n;
  logic          pre_wrap;

  assign pre_wrap = (pre_cnt == PW'(PRE - 1));
  assign bin_n    = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      bin_q   <= '0;
      gray_o  <= '0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) begin
        bin_q  <= bin_n;
        gray_o <= bin_n ^ (bin_n >> 1);
      end
    end
  end

  // R4
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/ld_window_judge.sv
module ld_window_judge
  import cdr_lock_pkg::*;
#(
  parameter int WIN = 16384,
  parameter int PRE = 64,
  parameter int PPM = 500,
  parameter int CW  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_i,
  input  logic          run_tgl_i,
  input  logic          run_sat_i,
  input  logic          sdet_i,
  input  logic [1:0]    sel_i,
  output logic          lock_o,
  output logic          force_o
);
  localparam int WW = $clog2(WIN);

  logic [CW-1:0] exp_tab [4];
  logic [CW-1:0] tol_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_rate
    assign exp_tab[g] = CW'(win_expect(WIN, PRE, 2'(g)));
    assign tol_tab[g] = CW'(win_tol(win_expect(WIN, PRE, 2'(g)), PPM));
  end

  logic [CW-1:0] cnt_bin, base_q, diff, lo_lim, hi_lim;
  logic [WW-1:0] win_cnt;
  logic          win_end, freq_ok, tgl_d, run_evt, drop, restart;
  lk_state_e     state_q, state_n;

  always_comb begin
    for (int i = 0; i < CW; i++) cnt_bin[i] = ^(gray_i >> i);
  end

  assign diff    = cnt_bin - base_q;
  assign lo_lim  = (exp_tab[sel_i] > tol_tab[sel_i]) ? exp_tab[sel_i] - tol_tab[sel_i] : '0;
  assign hi_lim  = exp_tab[sel_i] + tol_tab[sel_i];
  assign freq_ok = (diff >= lo_lim) && (diff <= hi_lim);
  assign win_end = (win_cnt == WW'(WIN - 1));
  assign run_evt = run_tgl_i ^ tgl_d;
  assign drop    = !sdet_i || run_evt || run_sat_i;

  always_comb begin
    state_n = state_q;
    restart = 1'b0;
    if (drop) begin
      state_n = LK_HUNT;
      restart = 1'b1;
    end else if (win_end) begin
      restart = 1'b1;
      case (state_q)
        LK_HUNT:    state_n = freq_ok ? LK_CONFIRM : LK_HUNT;
        LK_CONFIRM: state_n = freq_ok ? LK_HELD    : LK_HUNT;
        default:    state_n = freq_ok ? LK_HELD    : LK_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      base_q  <= '0;
      tgl_d   <= 1'b0;
      state_q <= LK_HUNT;
      lock_o  <= 1'b0;
      force_o <= 1'b1;
    end else begin
      win_cnt <= restart ? '0 : win_cnt + 1'b1;
      if (restart) base_q <= cnt_bin;
      tgl_d   <= run_tgl_i;
      state_q <= state_n;
      lock_o  <= (state_n == LK_HELD);
      force_o <= (state_n != LK_HELD);
    end
  end

  // R2
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(win_end && !drop && freq_ok && state_q == LK_CONFIRM));

  // R5
  sdet_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdet_i |=> !lock_o);

  // R7
  held_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_HELD && win_end && !freq_ok) |=> !lock_o);
endmodule

// File: rtl/cdr_lock_detect.sv
module cdr_lock_detect #(
  parameter int WIN       = 16384,
  parameter int PRE       = 64,
  parameter int PPM       = 500,
  parameter int RUN_LIMIT = 80
) (
  input  logic       clk_rec,
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       ser_din,
  input  logic       sig_det,
  input  logic [1:0] ref_sel,
  output logic       lock_o,
  output logic       force_ref_o
);
  localparam int CW = $clog2(WIN * 32 / PRE) + 2;

  logic [CW-1:0] gray_rec, gray_ref;
  logic          run_tgl, run_sat;
  logic [2:0]    flags_ref;

  ld_run_monitor #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk       (clk_rec),
    .rst_n     (rst_n),
    .din       (ser_din),
    .run_tgl_o (run_tgl),
    .run_sat_o (run_sat)
  );

  ld_rate_tally #(.PRE(PRE), .CW(CW)) u_tally (
    .clk    (clk_rec),
    .rst_n  (rst_n),
    .gray_o (gray_rec)
  );

  ld_sync2 #(.W(CW)) u_sync_cnt (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     (gray_rec),
    .q     (gray_ref)
  );

  ld_sync2 #(.W(3)) u_sync_flags (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     ({sig_det, run_sat, run_tgl}),
    .q     (flags_ref)
  );

  ld_window_judge #(.WIN(WIN), .PRE(PRE), .PPM(PPM), .CW(CW)) u_judge (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .gray_i    (gray_ref),
    .run_tgl_i (flags_ref[0]),
    .run_sat_i (flags_ref[1]),
    .sdet_i    (flags_ref[2]),
    .sel_i     (ref_sel),
    .lock_o    (lock_o),
    .force_o   (force_ref_o)
  );
endmodule

// File: tb/sim_cdr_lock_detect.sv
`timescale 1ns/1ps
module sim_cdr_lock_detect;
  localparam int WIN = 256;

  logic       clk_rec = 1'b0;
  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       ser_din = 1'b0;
  logic       sig_det = 1'b1;
  logic [1:0] ref_sel = 2'd3;
  logic       lock_o, force_ref_o;

  real ref_half = 16.0;
  int  pat = 0;
  int  n_chk = 0;
  int  n_bad = 0;

  cdr_lock_detect #(.WIN(WIN), .PRE(64), .PPM(20000), .RUN_LIMIT(80)) u0 (
    .clk_rec     (clk_rec),
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .ser_din     (ser_din),
    .sig_det     (sig_det),
    .ref_sel     (ref_sel),
    .lock_o      (lock_o),
    .force_ref_o (force_ref_o)
  );

  initial forever #2 clk_rec = ~clk_rec;
  initial forever #(ref_half) clk_ref = ~clk_ref;

  // serial pattern: 0 short runs 1..5, 1 runs of 79, 2 runs of 80, 3 held
  initial begin
    int run_pos = 0;
    int k = 0;
    forever begin
      @(negedge clk_rec);
      run_pos++;
      if (pat != 3 && run_pos >= ((pat == 0) ? 1 + k : (pat == 1) ? 79 : 80)) begin
        ser_din = ~ser_din;
        run_pos = 0;
        k = (k + 1) % 5;
      end
    end
  end

  // {sel, ref ratio index, pattern, sig_det, ten percent slow, expected lock}
  localparam logic [8:0] VEC [10] = '{
    {2'd3, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0},
    {2'd2, 2'd2, 2'd0, 1'b1, 1'b0, 1'b1},
    {2'd2, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1},
    {2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1}
  };

  function automatic real ratio_of(input logic [1:0] idx);
    case (idx)
      2'd0:    return 32.0;
      2'd1:    return 16.0;
      2'd2:    return 12.0;
      default: return 8.0;
    endcase
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge clk_ref);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk_rec);
    @(negedge clk_ref);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk_rec);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (6) @(negedge clk_rec);
    check(lock_o, 1'b0, "R1", "lock in reset");
    check(force_ref_o, 1'b1, "R1", "force in reset");

    for (int i = 0; i < 10; i++) begin
      logic [8:0] v;
      string req;
      v = VEC[i];
      ref_sel  = v[8:7];
      pat      = int'(v[4:3]);
      sig_det  = v[2];
      ref_half = ratio_of(v[6:5]) * 2.0 * (v[1] ? 1.1 : 1.0);
      if (!v[2])                         req = "R5";
      else if (v[1] || v[8:7] != v[6:5]) req = "R4";
      else if (v[4:3] == 2'd3)           req = "R9";
      else if (v[4:3] != 2'd0)           req = "R3";
      else                               req = "R2";
      do_reset();
      wait_ref(3 * WIN + 16);
      check(lock_o, v[0], req, $sformatf("vector %0d lock", i));
      check(force_ref_o, ~v[0], "R6", $sformatf("vector %0d force", i));
    end

    // R2: lock only at the end of the second good window
    ref_sel = 2'd3; pat = 0; sig_det = 1'b1; ref_half = 16.0;
    do_reset();
    wait_ref(WIN + 16);
    check(lock_o, 1'b0, "R2", "after one window");
    wait_ref(WIN - 24);
    check(lock_o, 1'b0, "R2", "just before second window end");
    wait_ref(24);
    check(lock_o, 1'b1, "R2", "after second window");

    // R5 then R8: signal loss while locked, then reacquire
    sig_det = 1'b0;
    wait_ref(6);
    check(lock_o, 1'b0, "R5", "signal loss");
    check(force_ref_o, 1'b1, "R6", "force on signal loss");
    sig_det = 1'b1;
    wait_ref(2 * WIN + 16);
    check(lock_o, 1'b1, "R8", "relock after signal");

    // R3 then R8: run of 80 while locked
    pat = 2;
    repeat (400) @(negedge clk_rec);
    wait_ref(8);
    check(lock_o, 1'b0, "R3", "run of 80 while locked");
    pat = 0;
    wait_ref(2 * WIN + 24);
    check(lock_o, 1'b1, "R8", "relock after runs");

    // R7 then R8: rate drift while locked
    ref_half = 17.6;
    wait_ref(2 * WIN + 16);
    check(lock_o, 1'b0, "R7", "rate drift while locked");
    wait_ref(WIN);
    check(lock_o, 1'b0, "R4", "drift stays unlocked");
    ref_half = 16.0;
    wait_ref(3 * WIN + 16);
    check(lock_o, 1'b1, "R8", "relock after drift");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule